// File: doc/BRIEF.md
# Wavetable Playback Channel

This block replays a 32-step waveform of 4-bit samples held in a 16-byte store. Every step is one nibble of that store. A programmable period timer sets the rate at which playback moves from step to step. The selected nibble is latched and then scaled by a 2-bit level code before it reaches the amplitude output.

A single register port reaches both the sample store and the control registers. The control registers hold a converter-enable bit, a length load, the level code and an 11-bit period. The period's high byte also carries a length-enable bit and a trigger bit. The surrounding sound unit supplies three inputs:
- a per-clock enable that advances the timer,
- a length strobe that counts the length counter down,
- a flag that marks whether the current sequencer step is odd.

The channel reports its amplitude and whether it is active. Mixing with other channels happens elsewhere.

Register port map (5-bit address):
- 0x00 to 0x0F: sample bytes.
- 0x10: converter enable.
- 0x11: length load.
- 0x12: level code.
- 0x13: period low byte.
- 0x14: period high bits and control.

Top module: `wavetbl_chan`

## Requirements
- R1: After synchronous reset, `active_o` is 0, `sample_o` is 0 and every sample byte reads back as 0x00.
- R2: A write to address 0x00 to 0x0F stores the byte. A read of the same address returns it on `reg_rdata`, whether or not the channel is playing.
- R3: Playback position p (5 bits) reads byte p>>1. An even p selects bits [7:4] and an odd p selects bits [3:0]. Each timer expiry latches the nibble at p and then advances p modulo 32.
- R4: The level code is bits [1:0] of address 0x12, and it applies to the latched nibble with no delay. Code 0 gives 0. Codes 1, 2 and 3 give the nibble shifted right by 0, 1 and 2 bits.
- R5: The period is {0x14[2:0], 0x13[7:0]}. A trigger (writing 0x14 with bit 7 set) sets position 0 and clears the latched nibble to 0, and the first nibble is latched on the third `tick_en` cycle. Later nibbles follow every (2048 - period) * 2 `tick_en` cycles.
- R6: Bit 7 of 0x10 enables the converter. Writing it as 0 makes the channel inactive on the next cycle. A trigger activates the channel only while the converter is enabled. `sample_o` is 0 whenever the channel is inactive.
- R7: Writing v to 0x11 loads the length counter with 256 - v. While length enable (0x14 bit 6) is set, each `len_tick` decrements a nonzero counter, and the decrement that reaches zero deactivates the channel.
- R8: A trigger finding the counter at zero reloads it to 256. It reloads to 255 instead when the same write sets length enable and `seq_odd` is 1.
- R9: A write that raises length enable from 0 to 1 while `seq_odd` is 1 takes one extra count off a nonzero counter. There is no extra count when `seq_odd` is 0 or when length enable was already set.
- R10: When a trigger coincides with a timer expiry, the trigger wins. When a `len_tick` coincides with a write to 0x14, the tick is applied first and the write acts on the result.
- R11: While `tick_en` is 0, the timer and position hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Advances the period timer by one count |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| len_tick | input | 1 | Length-counter decrement strobe |
| seq_odd | input | 1 | Current sequencer step is odd |
| sample_o | output | 4 | Scaled amplitude |
| active_o | output | 1 | Channel is playing |

## Verification
Two collisions get particular attention.

The first is a trigger write landing on the same cycle as a timer expiry. The bench brings the timer to one count from expiry and issues the trigger together with `tick_en`. It then expects the amplitude to drop to zero and the position-0 nibble to reappear exactly three ticks later; a nibble from position 1 would show that the expiry won.

The second is a length strobe landing on the same cycle as a trigger, with the counter at 1. The strobe empties the counter, and the trigger must then reload 256. The bench confirms this by observing that the channel survives 255 further strobes and falls silent on the 256th.

// File: rtl/wavetbl_pkg.sv
package wavetbl_pkg;
    localparam int unsigned SMP_W     = 4;
    localparam int unsigned POS_W     = 5;
    localparam int unsigned RAM_AW    = POS_W - 1;
    localparam int unsigned RAM_DEPTH = 1 << RAM_AW;
    localparam int unsigned BYTE_W    = 2 * SMP_W;
    localparam int unsigned PER_W     = 11;
    localparam int unsigned PER_HI_W  = PER_W - BYTE_W;
    localparam int unsigned TMR_W     = PER_W + 2;
    localparam int unsigned LEN_W     = 8;
    localparam int unsigned LCNT_W    = LEN_W + 1;
    localparam int unsigned START_DLY = 3;
    localparam int unsigned ADDR_W    = RAM_AW + 1;
    localparam int unsigned SEL_W     = 3;
    localparam int unsigned LVL_W     = 2;

    typedef enum logic [SEL_W-1:0] {
        CR_DAC = 3'd0,
        CR_LEN = 3'd1,
        CR_LVL = 3'd2,
        CR_PLO = 3'd3,
        CR_PHI = 3'd4
    } ctl_sel_e;

    typedef struct packed {
        logic ram_we;
        logic dac_we;
        logic len_we;
        logic lvl_we;
        logic plo_we;
        logic phi_we;
    } wr_dec_t;

    function automatic logic [SMP_W-1:0] pick_nib(input logic [BYTE_W-1:0] b,
                                                  input logic odd);
        return odd ? b[SMP_W-1:0] : b[BYTE_W-1:SMP_W];
    endfunction

    function automatic logic [SMP_W-1:0] scale_nib(input logic [SMP_W-1:0] n,
                                                   input logic [LVL_W-1:0] lvl);
        logic [SMP_W-1:0] r;
        case (lvl)
            2'd0:    r = '0;
            2'd1:    r = n;
            2'd2:    r = n >> 1;
            default: r = n >> 2;
        endcase
        return r;
    endfunction

    function automatic logic [TMR_W-1:0] reload_of(input logic [PER_W-1:0] per);
        logic [TMR_W-1:0] span;
        span = TMR_W'(1 << PER_W) - TMR_W'(per);
        return span << 1;
    endfunction
endpackage

// File: rtl/wavetbl_ram.sv
module wavetbl_ram
    import wavetbl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [RAM_AW-1:0] waddr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [RAM_AW-1:0] play_addr,
    output logic [BYTE_W-1:0] play_byte,
    input  logic [RAM_AW-1:0] bus_addr,
    output logic [BYTE_W-1:0] bus_byte
);
    logic [BYTE_W-1:0] mem [RAM_DEPTH];

    always_ff @(posedge clk) begin
        for (int i = 0; i < RAM_DEPTH; i++) begin
            if (rst)
                mem[i] <= '0;
            else if (we && waddr == RAM_AW'(i))
                mem[i] <= wdata;
        end
    end

    assign play_byte = mem[play_addr];
    assign bus_byte  = mem[bus_addr];
endmodule

// File: rtl/wavetbl_timer.sv
module wavetbl_timer
    import wavetbl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             trig,
    input  logic [PER_W-1:0] period,
    output logic [POS_W-1:0] pos_o,
    output logic             expire_o
);
    logic [TMR_W-1:0] cnt_q;
    logic [POS_W-1:0] pos_q;

    assign expire_o = tick_en && (cnt_q <= TMR_W'(1));
    assign pos_o    = pos_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            pos_q <= '0;
        end else if (trig) begin
            cnt_q <= TMR_W'(START_DLY);
            pos_q <= '0;
        end else if (expire_o) begin
            cnt_q <= reload_of(period);
            pos_q <= pos_q + 1'b1;
        end else if (tick_en) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/wavetbl_length.sv
module wavetbl_length
    import wavetbl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             len_tick,
    input  logic             seq_odd,
    input  logic             load_we,
    input  logic [LEN_W-1:0] load_val,
    input  logic             ctl_we,
    input  logic             en_wr,
    input  logic             trig,
    output logic             en_o,
    output logic             kill_o
);
    logic [LCNT_W-1:0] cnt_q, cnt_d;
    logic              en_q, en_d;
    logic              kill;

    always_comb begin
        cnt_d = cnt_q;
        kill  = 1'b0;
        en_d  = en_q;
        if (len_tick && en_q && cnt_d != '0) begin
            cnt_d = cnt_d - 1'b1;
            if (cnt_d == '0) kill = 1'b1;
        end
        if (load_we)
            cnt_d = LCNT_W'(1 << LEN_W) - LCNT_W'(load_val);
        if (ctl_we) begin
            en_d = en_wr;
            if (en_wr && !en_q && seq_odd && cnt_d != '0) begin
                cnt_d = cnt_d - 1'b1;
                if (cnt_d == '0) kill = 1'b1;
            end
            if (trig && cnt_d == '0) begin
                cnt_d = LCNT_W'(1 << LEN_W);
                if (en_wr && seq_odd) cnt_d = cnt_d - 1'b1;
            end
            if (en_wr && cnt_d == '0) kill = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            en_q  <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            en_q  <= en_d;
        end
    end

    assign en_o   = en_q;
    assign kill_o = kill;
endmodule

// File: rtl/wavetbl_chan.sv
module wavetbl_chan
    import wavetbl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic              len_tick,
    input  logic              seq_odd,
    output logic [SMP_W-1:0]  sample_o,
    output logic              active_o
);
    wr_dec_t           dec;
    logic              ctl_hit;
    logic              trig;
    logic              dac_q;
    logic [LVL_W-1:0]  lvl_q;
    logic [PER_W-1:0]  per_q;
    logic              active_q;
    logic [SMP_W-1:0]  nib_q;
    logic [POS_W-1:0]  pos_w;
    logic              expire_w;
    logic              len_en_w;
    logic              len_kill_w;
    logic [BYTE_W-1:0] play_byte_w;
    logic [BYTE_W-1:0] bus_byte_w;

    assign ctl_hit = reg_addr[ADDR_W-1] && (reg_addr[ADDR_W-2:SEL_W] == '0);

    always_comb begin
        dec = '0;
        if (reg_wr) begin
            if (!reg_addr[ADDR_W-1]) begin
                dec.ram_we = 1'b1;
            end else if (ctl_hit) begin
                case (ctl_sel_e'(reg_addr[SEL_W-1:0]))
                    CR_DAC:  dec.dac_we = 1'b1;
                    CR_LEN:  dec.len_we = 1'b1;
                    CR_LVL:  dec.lvl_we = 1'b1;
                    CR_PLO:  dec.plo_we = 1'b1;
                    CR_PHI:  dec.phi_we = 1'b1;
                    default: dec = '0;
                endcase
            end
        end
    end

    assign trig = dec.phi_we && reg_wdata[BYTE_W-1];

    wavetbl_ram u_ram (
        .clk       (clk),
        .rst       (rst),
        .we        (dec.ram_we),
        .waddr     (reg_addr[RAM_AW-1:0]),
        .wdata     (reg_wdata),
        .play_addr (pos_w[POS_W-1:1]),
        .play_byte (play_byte_w),
        .bus_addr  (reg_addr[RAM_AW-1:0]),
        .bus_byte  (bus_byte_w)
    );

    wavetbl_timer u_timer (
        .clk      (clk),
        .rst      (rst),
        .tick_en  (tick_en),
        .trig     (trig),
        .period   (per_q),
        .pos_o    (pos_w),
        .expire_o (expire_w)
    );

    wavetbl_length u_length (
        .clk      (clk),
        .rst      (rst),
        .len_tick (len_tick),
        .seq_odd  (seq_odd),
        .load_we  (dec.len_we),
        .load_val (reg_wdata),
        .ctl_we   (dec.phi_we),
        .en_wr    (reg_wdata[BYTE_W-2]),
        .trig     (trig),
        .en_o     (len_en_w),
        .kill_o   (len_kill_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dac_q    <= 1'b0;
            lvl_q    <= '0;
            per_q    <= '0;
            active_q <= 1'b0;
            nib_q    <= '0;
        end else begin
            if (dec.dac_we) dac_q <= reg_wdata[BYTE_W-1];
            if (dec.lvl_we) lvl_q <= reg_wdata[LVL_W-1:0];
            if (dec.plo_we) per_q[BYTE_W-1:0] <= reg_wdata;
            if (dec.phi_we) per_q[PER_W-1:BYTE_W] <= reg_wdata[PER_HI_W-1:0];

            if (trig)
                active_q <= dac_q;
            else if ((dec.dac_we && !reg_wdata[BYTE_W-1]) || len_kill_w)
                active_q <= 1'b0;

            if (trig)
                nib_q <= '0;
            else if (expire_w)
                nib_q <= pick_nib(play_byte_w, pos_w[0]);
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (!reg_addr[ADDR_W-1]) begin
            reg_rdata = bus_byte_w;
        end else if (ctl_hit) begin
            case (ctl_sel_e'(reg_addr[SEL_W-1:0]))
                CR_DAC:  reg_rdata[BYTE_W-1] = dac_q;
                CR_LVL:  reg_rdata[LVL_W-1:0] = lvl_q;
                CR_PHI:  reg_rdata[BYTE_W-2] = len_en_w;
                default: reg_rdata = '0;
            endcase
        end
    end

    assign active_o = active_q;
    assign sample_o = active_q ? scale_nib(nib_q, lvl_q) : '0;
endmodule

// File: rtl/wavetbl_chk.sv
module wavetbl_chk
    import wavetbl_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              tick_en,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [BYTE_W-1:0] reg_wdata,
    input logic              trig,
    input logic              dac_q,
    input logic [LVL_W-1:0]  lvl_q,
    input logic              expire_w,
    input logic [POS_W-1:0]  pos_w,
    input logic              active_o,
    input logic [SMP_W-1:0]  sample_o
);
    localparam logic [ADDR_W-1:0] DAC_ADDR = ADDR_W'(RAM_DEPTH) + ADDR_W'(CR_DAC);

    p_dac_off_r6: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == DAC_ADDR && !reg_wdata[BYTE_W-1]) |=> !active_o);

    p_trig_on_r6: assert property (@(posedge clk) disable iff (rst)
        (trig && dac_q) |=> active_o);

    p_trig_pos_r5: assert property (@(posedge clk) disable iff (rst)
        trig |=> (pos_w == '0));

    p_pos_step_r3: assert property (@(posedge clk) disable iff (rst)
        (expire_w && !trig) |=> (pos_w == $past(pos_w) + 1'b1));

    p_level_bound_r4: assert property (@(posedge clk) disable iff (rst)
        (lvl_q == 2'd3) |-> (sample_o <= SMP_W'(3)));

    p_stay_off_r7: assert property (@(posedge clk) disable iff (rst)
        (!active_o && !trig) |=> !active_o);

    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (!tick_en && !trig) |=> $stable(pos_w));
endmodule

bind wavetbl_chan wavetbl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick_en   (tick_en),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .trig      (trig),
    .dac_q     (dac_q),
    .lvl_q     (lvl_q),
    .expire_w  (expire_w),
    .pos_w     (pos_w),
    .active_o  (active_o),
    .sample_o  (sample_o)
);

// File: tb/test_wavetbl_chan.sv
module test_wavetbl_chan;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b0;
    logic       reg_wr = 1'b0;
    logic [4:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       len_tick = 1'b0;
    logic       seq_odd = 1'b0;
    logic [3:0] sample_o;
    logic       active_o;

    int n_run  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    wavetbl_chan i_wavetbl_chan (
        .clk       (clk),
        .rst       (rst),
        .tick_en   (tick_en),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .len_tick  (len_tick),
        .seq_odd   (seq_odd),
        .sample_o  (sample_o),
        .active_o  (active_o)
    );

    function automatic logic [3:0] hi_of(input int i);
        return 4'((i * 5 + 7) & 15);
    endfunction
    function automatic logic [3:0] lo_of(input int i);
        return 4'((i * 3 + 2) & 15);
    endfunction
    function automatic logic [3:0] nib_at(input int p);
        return p[0] ? lo_of((p & 31) >> 1) : hi_of((p & 31) >> 1);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic tick(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic lpulse(input int n);
        repeat (n) begin
            @(negedge clk); len_tick = 1'b1;
            @(negedge clk); len_tick = 1'b0;
        end
    endtask

    task automatic t_reset;
        logic [7:0] d;
        check("R1 active", active_o, 0);
        check("R1 sample", sample_o, 0);
        rd(5'h03, d);
        check("R1 ram", d, 0);
    endtask

    task automatic t_setup;
        for (int i = 0; i < 16; i++) wr(5'(i), {hi_of(i), lo_of(i)});
        wr(5'h10, 8'h80);
        wr(5'h12, 8'h01);
        wr(5'h13, 8'hFF);
    endtask

    task automatic t_sequence;
        wr(5'h14, 8'h87);
        check("R6 trigger active", active_o, 1);
        check("R5 cleared on trigger", sample_o, 0);
        tick(2);
        check("R5 no sample before third tick", sample_o, 0);
        tick(1);
        check("R5 first sample", sample_o, nib_at(0));
        for (int k = 1; k <= 33; k++) begin
            tick(1);
            if (k == 1) check("R5 half period holds", sample_o, nib_at(0));
            tick(1);
            check($sformatf("R3 position %0d", k), sample_o, nib_at(k));
        end
    endtask

    task automatic t_level;
        wr(5'h14, 8'h87);
        tick(3);
        check("R4 level 1", sample_o, 7);
        wr(5'h12, 8'h02);
        check("R4 level 2", sample_o, 3);
        wr(5'h12, 8'h03);
        check("R4 level 3", sample_o, 1);
        wr(5'h12, 8'h00);
        check("R4 level 0 mutes", sample_o, 0);
        wr(5'h12, 8'h01);
        check("R4 level back to 1", sample_o, 7);
    endtask

    task automatic t_hold;
        repeat (10) @(negedge clk);
        check("R11 held without ticks", sample_o, nib_at(0));
        tick(1);
        check("R11 one tick of two", sample_o, nib_at(0));
        tick(1);
        check("R11 next after second", sample_o, nib_at(1));
    endtask

    task automatic t_trig_vs_expire;
        wr(5'h14, 8'h87);
        tick(3);
        tick(1);
        check("R10 setup", sample_o, nib_at(0));
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 5'h14; reg_wdata = 8'h87; tick_en = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; tick_en = 1'b0;
        check("R10 trigger beats expiry", sample_o, 0);
        tick(2);
        check("R10 restart delay", sample_o, 0);
        tick(1);
        check("R10 position 0 again", sample_o, nib_at(0));
    endtask

    task automatic t_length;
        seq_odd = 1'b0;
        wr(5'h11, 8'd253);
        wr(5'h14, 8'hC7);
        check("R7 active after trigger", active_o, 1);
        lpulse(2);
        check("R7 even edge no extra", active_o, 1);
        lpulse(1);
        check("R7 expires at zero", active_o, 0);
        check("R6 silent when inactive", sample_o, 0);
        wr(5'h14, 8'hC7);
        lpulse(255);
        check("R8 reload 256 alive", active_o, 1);
        lpulse(1);
        check("R8 reload 256 ends", active_o, 0);
        seq_odd = 1'b1;
        wr(5'h14, 8'hC7);
        seq_odd = 1'b0;
        lpulse(254);
        check("R8 odd reload 255 alive", active_o, 1);
        lpulse(1);
        check("R8 odd reload 255 ends", active_o, 0);
    endtask

    task automatic t_tick_vs_write;
        wr(5'h11, 8'd255);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 5'h14; reg_wdata = 8'hC7; len_tick = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; len_tick = 1'b0;
        check("R10 trigger survives tick", active_o, 1);
        lpulse(255);
        check("R10 tick then reload alive", active_o, 1);
        lpulse(1);
        check("R10 tick then reload ends", active_o, 0);
    endtask

    task automatic t_edge;
        logic [7:0] d;
        wr(5'h14, 8'h07);
        rd(5'h14, d);
        check("R9 length enable clear", d, 0);
        wr(5'h11, 8'd253);
        wr(5'h14, 8'h87);
        seq_odd = 1'b1;
        wr(5'h14, 8'h47);
        lpulse(1);
        check("R9 odd edge extra count alive", active_o, 1);
        lpulse(1);
        check("R9 odd edge extra count ends", active_o, 0);
        wr(5'h11, 8'd253);
        wr(5'h14, 8'hC7);
        seq_odd = 1'b0;
        lpulse(2);
        check("R9 no extra when already on", active_o, 1);
        lpulse(1);
        check("R9 already on ends", active_o, 0);
        wr(5'h14, 8'h07);
    endtask

    task automatic t_dac;
        logic [7:0] d;
        wr(5'h14, 8'h87);
        check("R6 on", active_o, 1);
        wr(5'h10, 8'h00);
        check("R6 converter off kills", active_o, 0);
        wr(5'h14, 8'h87);
        check("R6 trigger with converter off", active_o, 0);
        wr(5'h10, 8'h80);
        check("R6 enable alone no start", active_o, 0);
        rd(5'h10, d);
        check("R6 readback", d, 8'h80);
        wr(5'h14, 8'h87);
        check("R6 trigger restarts", active_o, 1);
    endtask

    task automatic t_ram;
        logic [7:0] d;
        tick(5);
        wr(5'h05, 8'hA5);
        rd(5'h05, d);
        check("R2 readback while playing", d, 8'hA5);
        rd(5'h00, d);
        check("R2 readback byte 0", d, {hi_of(0), lo_of(0)});
        wr(5'h10, 8'h00);
        rd(5'h05, d);
        check("R2 readback while stopped", d, 8'hA5);
    endtask

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_setup();
        t_sequence();
        t_level();
        t_hold();
        t_trig_vs_expire();
        t_length();
        t_tick_vs_write();
        t_edge();
        t_dac();
        t_ram();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule